// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timing Generator

This block sits between a serial flash sequencer and the flash pins. It derives the serial clock from the faster system clock, owns the active-low chip select, and places every clock edge and every chip-select change on the system-clock grid. The sequencer hands over one element at a time: a number of clock periods to run, and a flag that says whether chip select is released at the end of that element. In return the block emits one-cycle shift and sample strobes, the clock and chip-select pins, an enable for the data output drivers, a ready signal, and a done pulse.

A divider value and a 32-bit timing word sit in holding registers that are written with a load strobe. All timing counts are in system clocks. The divider is forced to an even value between 2 and 128. The timing word holds four fields: the minimum chip-select-high time in bits 15:4, the chip-select setup/hold count in bits 23:16, and the data-hold count in bits 31:24. Bits 3:0 carry a device-type code, which this block ignores. Both registers are copied into a private snapshot when an element is accepted. A write made while an element runs therefore changes only the elements that follow it.

The controller has six states. IDLE: chip select high, ready. SETUP: chip select low, waiting out the setup count. RUN: clocking. TAIL: after the last falling edge, covering the chip-select hold and the data hold. GAP: chip select high, ready held low for the minimum-high time. HELD: chip select kept low between elements, ready.

The transitions are:
- IDLE goes to SETUP on a request when the setup count is non-zero, and to RUN when it is zero.
- HELD goes to RUN on a request.
- SETUP goes to RUN when its count expires.
- RUN goes to TAIL after the final high phase when the tail window is non-zero. Otherwise it goes straight to the TAIL's own successor.
- TAIL goes to GAP when the element releases chip select and the gap count is non-zero, to IDLE when it releases with a zero gap count, and to HELD when it does not release.
- GAP goes to IDLE when its count expires.

Top module: `spi_tgen`

## Requirements
- R1: After reset: cs_n=1, sck=0, req_ready=1, drv_en=0, done=0, shift_stb=0, sample_stb=0. The holding registers reset to divider 128, setup/hold 0xA0, minimum-high 0x0AA, data hold 0.
- R2: The effective divider is 2 when the register value is below 2, and 128 when it is above 128. An odd value in range is rounded up by one. Each SCK high phase and each low phase between high phases lasts half the effective divider in system clocks.
- R3: The timing word fields are min-high = bits 15:4, setup/hold = bits 23:16, data hold = bits 31:24. Bits 3:0 have no effect on any output.
- R4: An element accepted with chip select high keeps cs_n low and sck low for setup/hold plus half-divider clocks before the first rising SCK edge. An element accepted in HELD waits only half-divider clocks.
- R5: An element of N periods (N=0 counts as 1) gives exactly N sample strobes and N shift strobes. Each strobe is one clock wide. A sample strobe coincides with the first clock of each high phase. A shift strobe coincides with the first clock of each low phase and is never high while sck is high.
- R6: An element that releases chip select holds cs_n low for setup/hold clocks after its last falling SCK edge, and then raises it.
- R7: drv_en is high throughout clocking, and for data-hold clocks after the last falling edge, then low.
- R8: After a releasing element completes, cs_n stays high and req_ready low for min-high clocks. When data hold exceeds setup/hold, cs_n also rises (data hold − setup/hold) clocks before completion.
- R9: An element that does not release chip select keeps cs_n low and returns to ready data-hold clocks after its last falling edge. The next element then skips the setup wait.
- R10: done is a one-clock pulse in the first clock after each element ends.
- R11: The divider and the timing word are sampled when an element is accepted. A register write during an element affects only later elements.
- R12: An element is accepted on a clock edge with req_valid and req_ready both high. req_ready is high only in IDLE and HELD, and cs_n falls only after an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the divider and timing registers |
| cfg_div | input | 8 | Divider value to load |
| cfg_timing | input | 32 | Timing word to load |
| req_valid | input | 1 | Sequencer presents an element |
| req_ready | output | 1 | Block can accept an element |
| req_periods | input | 16 | Number of SCK periods in the element |
| req_release | input | 1 | Raise chip select at the end of the element |
| done | output | 1 | One-clock pulse when an element ends |
| sck | output | 1 | Serial clock pin, idles low |
| cs_n | output | 1 | Active-low chip select pin |
| shift_stb | output | 1 | Launch strobe at each low-phase start |
| sample_stb | output | 1 | Capture strobe at each rising edge |
| drv_en | output | 1 | Data output driver enable |

## Verification
The bench measures every element at the pins and compares what it sees against values computed from the configured fields. It times the wait before the first rising edge and the length of each high and low phase. After the last falling edge it counts the cycles with cs_n low, the cycles with cs_n high and the cycles with drv_en high, and after done it counts how long req_ready stays low.

It targets the divider boundaries 0, 1, 2, 3, 127, 128, 129 and 255, where a missing clamp or missing round-up shows up as a wrong phase length. It also covers:
- setup, hold and gap counts of zero, where an off-by-one adds or drops a cycle;
- data hold longer than setup/hold, where cs_n has to rise before done;
- chains of non-releasing elements, where a design that repeats the setup wait fails the first-edge timing;
- a zero period count;
- a register write made in the middle of an element, which a design without a snapshot would apply at once.

// File: rtl/spi_tgen_pkg.sv
package spi_tgen_pkg;

    localparam int unsigned TG_DIV_W = 8;
    localparam int unsigned TG_PER_W = 16;

    // Bit positions in the timing word; the controller decodes them.
    localparam int unsigned TG_GAP_LSB = 4;
    localparam int unsigned TG_GAP_MSB = 15;
    localparam int unsigned TG_SH_LSB  = 16;
    localparam int unsigned TG_SH_MSB  = 23;
    localparam int unsigned TG_DH_LSB  = 24;
    localparam int unsigned TG_DH_MSB  = 31;

    localparam int unsigned TG_GAP_W = TG_GAP_MSB - TG_GAP_LSB + 1;
    localparam int unsigned TG_SH_W  = TG_SH_MSB - TG_SH_LSB + 1;
    localparam int unsigned TG_DH_W  = TG_DH_MSB - TG_DH_LSB + 1;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_RUN   = 3'd2,
        ST_TAIL  = 3'd3,
        ST_GAP   = 3'd4,
        ST_HELD  = 3'd5
    } tg_state_e;

endpackage

// File: rtl/spi_tgen_cfg.sv
module spi_tgen_cfg
    import spi_tgen_pkg::*;
#(
    parameter int unsigned DIV_W      = TG_DIV_W,
    parameter int unsigned DIV_MIN    = 2,
    parameter int unsigned DIV_MAX    = 128,
    parameter int unsigned RST_DIV    = 128,
    parameter logic [31:0] RST_TIMING = 32'h00A0_0AA1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [DIV_W-1:0]    div_in,
    input  logic [31:TG_GAP_LSB] tim_in,
    output logic [DIV_W-1:0]    half_o,
    output logic [TG_SH_W-1:0]  sh_o,
    output logic [TG_DH_W-1:0]  dh_o,
    output logic [TG_GAP_W-1:0] gap_o
);

    localparam logic [DIV_W-1:0] DMIN = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] DMAX = DIV_W'(DIV_MAX);

    logic [DIV_W-1:0]     div_q;
    logic [31:TG_GAP_LSB] tim_q;
    logic [DIV_W-1:0]     eff_div;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_W'(RST_DIV);
            tim_q <= RST_TIMING[31:TG_GAP_LSB];
        end else if (we) begin
            div_q <= div_in;
            tim_q <= tim_in;
        end
    end

    // Force the divider into the legal even range.
    always_comb begin
        if (div_q < DMIN) begin
            eff_div = DMIN;
        end else if (div_q > DMAX) begin
            eff_div = DMAX;
        end else begin
            eff_div = div_q + {{(DIV_W-1){1'b0}}, div_q[0]};
        end
    end

    assign half_o = eff_div >> 1;
    assign gap_o  = tim_q[TG_GAP_MSB:TG_GAP_LSB];
    assign sh_o   = tim_q[TG_SH_MSB:TG_SH_LSB];
    assign dh_o   = tim_q[TG_DH_MSB:TG_DH_LSB];

endmodule

// File: rtl/spi_tgen_clkgen.sv
module spi_tgen_clkgen #(
    parameter int unsigned HALF_W = 8,
    parameter int unsigned PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              en,
    input  logic [HALF_W-1:0] half,
    input  logic [PER_W-1:0]  periods,
    output logic              sck_o,
    output logic              shift_o,
    output logic              sample_o,
    output logic              last_o
);

    logic [HALF_W-1:0] hcnt_q;
    logic              hi_q;
    logic [PER_W-1:0]  pcnt_q;
    logic              phase_end;

    assign phase_end = (hcnt_q == half - HALF_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q <= '0;
            hi_q   <= 1'b0;
            pcnt_q <= '0;
        end else if (start) begin
            hcnt_q <= '0;
            hi_q   <= 1'b0;
            pcnt_q <= (periods == '0) ? PER_W'(1) : periods;
        end else if (en) begin
            if (phase_end) begin
                hcnt_q <= '0;
                hi_q   <= ~hi_q;
                if (hi_q) begin
                    pcnt_q <= pcnt_q - PER_W'(1);
                end
            end else begin
                hcnt_q <= hcnt_q + HALF_W'(1);
            end
        end
    end

    assign sck_o    = en & hi_q;
    assign sample_o = en & hi_q & (hcnt_q == '0);
    assign shift_o  = en & ~hi_q & (hcnt_q == '0);
    assign last_o   = en & hi_q & phase_end & (pcnt_q == PER_W'(1));

endmodule

// File: rtl/spi_tgen_timer.sv
module spi_tgen_timer #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CMAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr) begin
            cnt_o <= '0;
        end else if (cnt_o != CMAX) begin
            cnt_o <= cnt_o + W'(1);
        end
    end

endmodule

// File: rtl/spi_tgen.sv
module spi_tgen
    import spi_tgen_pkg::*;
#(
    parameter int unsigned DIV_W      = TG_DIV_W,
    parameter int unsigned PER_W      = TG_PER_W,
    parameter int unsigned DIV_MIN    = 2,
    parameter int unsigned DIV_MAX    = 128,
    parameter int unsigned RST_DIV    = 128,
    parameter logic [31:0] RST_TIMING = 32'h00A0_0AA1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [31:0]      cfg_timing,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PER_W-1:0] req_periods,
    input  logic             req_release,
    output logic             done,
    output logic             sck,
    output logic             cs_n,
    output logic             shift_stb,
    output logic             sample_stb,
    output logic             drv_en
);

    localparam int unsigned CNT_W = (TG_GAP_W > TG_SH_W) ?
                                    ((TG_GAP_W > TG_DH_W) ? TG_GAP_W : TG_DH_W) :
                                    ((TG_SH_W > TG_DH_W) ? TG_SH_W : TG_DH_W);

    tg_state_e st_q, st_d;

    logic [DIV_W-1:0]    cur_half, half_q;
    logic [TG_SH_W-1:0]  cur_sh, sh_q;
    logic [TG_DH_W-1:0]  cur_dh, dh_q;
    logic [TG_GAP_W-1:0] cur_gap, gap_q;
    logic [PER_W-1:0]    per_q, per_mux;
    logic                rel_q;
    logic                accept;
    logic                run_start, run_last;
    logic                gen_sck, gen_shift, gen_sample;
    logic [CNT_W-1:0]    tcnt, tail_q;
    logic                done_q, elem_end;
    logic                unused_devcode;

    // Device-type code bits carry no behaviour here.
    assign unused_devcode = ^cfg_timing[TG_GAP_LSB-1:0];

    spi_tgen_cfg #(
        .DIV_W     (DIV_W),
        .DIV_MIN   (DIV_MIN),
        .DIV_MAX   (DIV_MAX),
        .RST_DIV   (RST_DIV),
        .RST_TIMING(RST_TIMING)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .div_in(cfg_div),
        .tim_in(cfg_timing[31:TG_GAP_LSB]),
        .half_o(cur_half),
        .sh_o  (cur_sh),
        .dh_o  (cur_dh),
        .gap_o (cur_gap)
    );

    // Tail window: data hold alone, or the longer of hold and setup/hold on release.
    function automatic logic [CNT_W-1:0] tail_len(input logic rel,
                                                  input logic [TG_SH_W-1:0] sh,
                                                  input logic [TG_DH_W-1:0] dh);
        logic [CNT_W-1:0] s;
        logic [CNT_W-1:0] d;
        s = CNT_W'(sh);
        d = CNT_W'(dh);
        if (rel && (s > d)) begin
            return s;
        end
        return d;
    endfunction

    function automatic tg_state_e after_tail(input logic rel,
                                             input logic [TG_GAP_W-1:0] gap);
        if (!rel) begin
            return ST_HELD;
        end
        return (gap != '0) ? ST_GAP : ST_IDLE;
    endfunction

    assign accept  = req_valid & req_ready;
    assign tail_q  = tail_len(rel_q, sh_q, dh_q);
    assign per_mux = accept ? req_periods : per_q;

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d = (cur_sh != '0) ? ST_SETUP : ST_RUN;
                end
            end
            ST_HELD: begin
                if (req_valid) begin
                    st_d = ST_RUN;
                end
            end
            ST_SETUP: begin
                if (tcnt == CNT_W'(sh_q) - CNT_W'(1)) begin
                    st_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (run_last) begin
                    st_d = (tail_q != '0) ? ST_TAIL : after_tail(rel_q, gap_q);
                end
            end
            ST_TAIL: begin
                if (tcnt == tail_q - CNT_W'(1)) begin
                    st_d = after_tail(rel_q, gap_q);
                end
            end
            ST_GAP: begin
                if (tcnt == CNT_W'(gap_q) - CNT_W'(1)) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Element snapshot taken at acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= DIV_W'(1);
            sh_q   <= '0;
            dh_q   <= '0;
            gap_q  <= '0;
            per_q  <= '0;
            rel_q  <= 1'b0;
        end else if (accept) begin
            half_q <= cur_half;
            sh_q   <= cur_sh;
            dh_q   <= cur_dh;
            gap_q  <= cur_gap;
            per_q  <= req_periods;
            rel_q  <= req_release;
        end
    end

    assign elem_end = ((st_q == ST_RUN) || (st_q == ST_TAIL)) &&
                      ((st_d == ST_IDLE) || (st_d == ST_HELD) || (st_d == ST_GAP));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= elem_end;
        end
    end

    spi_tgen_timer #(.W(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (st_d != st_q),
        .cnt_o(tcnt)
    );

    assign run_start = (st_d == ST_RUN) && (st_q != ST_RUN);

    spi_tgen_clkgen #(
        .HALF_W(DIV_W),
        .PER_W (PER_W)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (run_start),
        .en      (st_q == ST_RUN),
        .half    (half_q),
        .periods (per_mux),
        .sck_o   (gen_sck),
        .shift_o (gen_shift),
        .sample_o(gen_sample),
        .last_o  (run_last)
    );

    // Output decode.
    always_comb begin
        req_ready  = (st_q == ST_IDLE) || (st_q == ST_HELD);
        cs_n       = (st_q == ST_IDLE) || (st_q == ST_GAP) ||
                     ((st_q == ST_TAIL) && rel_q && (tcnt >= CNT_W'(sh_q)));
        drv_en     = (st_q == ST_RUN) ||
                     ((st_q == ST_TAIL) && (tcnt < CNT_W'(dh_q)));
        sck        = gen_sck;
        shift_stb  = gen_shift;
        sample_stb = gen_sample;
        done       = done_q;
    end

endmodule

// File: rtl/spi_tgen_chk.sv
module spi_tgen_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic sck,
    input logic cs_n,
    input logic shift_stb,
    input logic sample_stb,
    input logic drv_en
);

    a_r4_sck_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    a_r5_rise_samples: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> sample_stb);

    a_r5_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_stb, sample_stb}));

    a_r5_shift_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |-> !sck);

    a_r7_drive_covers_clock: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> drv_en);

    a_r7_release_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> !sck);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_fall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(req_valid && req_ready));

    a_r12_ready_idle_drivers: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !drv_en);

endmodule

bind spi_tgen spi_tgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .sck       (sck),
    .cs_n      (cs_n),
    .shift_stb (shift_stb),
    .sample_stb(sample_stb),
    .drv_en    (drv_en)
);

// File: tb/spi_tgen_bench.sv
`timescale 1ns/1ps
module spi_tgen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_div = '0;
    logic [31:0] cfg_timing = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_periods = '0;
    logic        req_release = 1'b0;
    logic        done, sck, cs_n, shift_stb, sample_stb, drv_en;

    int n_chk = 0;
    int n_bad = 0;
    int m_half, m_sh, m_dh, m_gap;
    bit cs_high_prev;

    always #2.5 clk = ~clk;

    spi_tgen u_spi_tgen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
        .cfg_timing(cfg_timing), .req_valid(req_valid), .req_ready(req_ready),
        .req_periods(req_periods), .req_release(req_release), .done(done),
        .sck(sck), .cs_n(cs_n), .shift_stb(shift_stb), .sample_stb(sample_stb),
        .drv_en(drv_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_div(input int d);
        if (d < 2) return 2;
        if (d > 128) return 128;
        return d + (d % 2);
    endfunction

    function automatic logic [31:0] tword(input int gap, input int sh,
                                          input int dh, input int code);
        return {dh[7:0], sh[7:0], gap[11:0], code[3:0]};
    endfunction

    task automatic model_cfg(input int d, input logic [31:0] t);
        m_half = eff_div(d) / 2;
        m_gap  = int'(t[15:4]);
        m_sh   = int'(t[23:16]);
        m_dh   = int'(t[31:24]);
    endtask

    task automatic write_cfg(input int d, input logic [31:0] t);
        cfg_we = 1'b1; cfg_div = d[7:0]; cfg_timing = t;
        @(negedge clk);
        cfg_we = 1'b0;
        model_cfg(d, t);
    endtask

    // Runs one element and measures it at the pins; called right after a negedge.
    task automatic do_elem(input int n, input bit rel, input bit mid_wr,
                           input int d2, input logic [31:0] t2, input string tag);
        int e_half, e_sh, e_dh, e_gap, nn, pre_exp;
        int pre, samp, shft, hirun, lorun, cs_lo, cs_hi, drv, guard, g;
        bit seen_hi, prev_sck, first_nr;
        e_half = m_half; e_sh = m_sh; e_dh = m_dh; e_gap = m_gap;
        nn = (n == 0) ? 1 : n;
        pre_exp = (cs_high_prev ? e_sh : 0) + e_half;
        pre = 0; samp = 0; shft = 0; hirun = 0; lorun = 0;
        cs_lo = 0; cs_hi = 0; drv = 0; guard = 0;
        seen_hi = 0; prev_sck = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_periods = n[15:0]; req_release = rel;
        @(negedge clk);
        req_valid = 1'b0;
        if (mid_wr) begin
            cfg_we = 1'b1; cfg_div = d2[7:0]; cfg_timing = t2;
        end
        forever begin
            if (!sck && prev_sck) begin
                chk({tag, " R2 high phase"}, hirun, e_half);
                hirun = 0; lorun = 0;
            end
            if (done || guard > 20000) break;
            if (sck) begin
                if (!prev_sck && seen_hi) chk({tag, " R2 low phase"}, lorun, e_half);
                hirun++; seen_hi = 1; cs_lo = 0; cs_hi = 0; drv = 0;
            end else begin
                if (!seen_hi && !cs_n) pre++;
                if (seen_hi) begin
                    lorun++;
                    if (!cs_n) cs_lo++; else cs_hi++;
                    if (drv_en) drv++;
                end
            end
            samp += int'(sample_stb);
            shft += int'(shift_stb);
            prev_sck = sck;
            @(negedge clk);
            guard++;
            if (guard == 1) cfg_we = 1'b0;
        end
        chk({tag, " R4 wait before first rise"}, pre, pre_exp);
        chk({tag, " R5 sample strobes"}, samp, nn);
        chk({tag, " R5 shift strobes"}, shft, nn);
        chk({tag, " R7 drive after last fall"}, drv, e_dh);
        if (rel) begin
            chk({tag, " R6 cs low after last fall"}, cs_lo, e_sh);
            chk({tag, " R8 cs high before done"}, cs_hi, (e_dh > e_sh) ? e_dh - e_sh : 0);
        end else begin
            chk({tag, " R9 cs held through tail"}, cs_lo, e_dh);
            chk({tag, " R9 cs never high"}, cs_hi, 0);
        end
        first_nr = !req_ready;
        g = first_nr ? 1 : 0;
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, int'(done), 0);
        if (first_nr) begin
            while (!req_ready && g < 20000) begin
                if (!cs_n) chk({tag, " R8 cs high in gap"}, int'(cs_n), 1);
                g++;
                @(negedge clk);
            end
        end
        chk({tag, " R8 min cs-high gap"}, g, rel ? e_gap : 0);
        chk({tag, " R9 cs level when ready"}, int'(cs_n), rel ? 1 : 0);
        cs_high_prev = rel;
        if (mid_wr) model_cfg(d2, t2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        int divs [8] = '{0, 1, 2, 3, 127, 128, 129, 255};
        seed = $urandom(32'd7331);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs_n reset", int'(cs_n), 1);
        chk("R1 sck reset", int'(sck), 0);
        chk("R1 ready reset", int'(req_ready), 1);
        chk("R1 drv_en reset", int'(drv_en), 0);
        chk("R1 done reset", int'(done), 0);
        chk("R1 strobes reset", int'(shift_stb) + int'(sample_stb), 0);

        // Reset defaults: divider 128, setup 0xA0, gap 0xAA, hold 0.
        model_cfg(128, 32'h00A0_0AA1);
        cs_high_prev = 1;
        do_elem(2, 1, 0, 0, '0, "R1 defaults");

        foreach (divs[i]) begin
            write_cfg(divs[i], tword(3, 2, 1, 1));
            do_elem(2, 1, 0, 0, '0, "R2 clamp");
        end

        write_cfg(4, tword(2, 3, 1, 4));
        do_elem(0, 1, 0, 0, '0, "R5 zero count");

        // Chain without release, then release (R9).
        do_elem(3, 0, 0, 0, '0, "R9 chain a");
        do_elem(1, 0, 0, 0, '0, "R9 chain b");
        do_elem(2, 1, 0, 0, '0, "R9 chain end");

        // Data hold longer than setup/hold (R7, R8).
        write_cfg(6, tword(2, 1, 5, 1));
        do_elem(2, 1, 0, 0, '0, "R8 long hold");

        // All counts zero (R4, R8).
        write_cfg(2, tword(0, 0, 0, 1));
        do_elem(1, 1, 0, 0, '0, "R4 zero counts");
        do_elem(2, 1, 0, 0, '0, "R8 zero gap back to back");

        // Mid-element write applies only to the next element (R11).
        write_cfg(8, tword(4, 2, 2, 1));
        do_elem(2, 1, 1, 14, tword(6, 5, 3, 1), "R11 snapshot");
        do_elem(2, 1, 0, 0, '0, "R11 new values");

        // Device code bits have no effect (R3).
        write_cfg(6, tword(3, 2, 1, 15));
        do_elem(2, 1, 0, 0, '0, "R3 code 0xF");
        write_cfg(6, tword(3, 2, 1, 4));
        do_elem(2, 0, 0, 0, '0, "R3 code 0x4");
        do_elem(1, 1, 0, 0, '0, "R12 after hold");

        for (int k = 0; k < 40; k++) begin
            int d, sh, dh, gp, code, n;
            bit rel;
            d = int'($urandom % 22); sh = int'($urandom % 7); dh = int'($urandom % 7);
            gp = int'($urandom % 9); code = int'($urandom % 16);
            n = 1 + int'($urandom % 4); rel = 1'($urandom % 2);
            if (rel || cs_high_prev) write_cfg(d, tword(gp, sh, dh, code));
            do_elem(n, rel, 0, 0, '0, "R3 random");
        end
        do_elem(1, 1, 0, 0, '0, "R12 final release");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule